// File: doc/BRIEF.md
# Shared Pad Domain Power and Clamp Sequencer

This block sequences the power and isolation controls of an I/O pad domain that several clients share. Clients send one-cycle enable and disable requests. A reference count records how many clients hold the domain, and only the transitions of that count between zero and one touch the hardware. The first enable releases the domain. The last disable puts it back into its clamped, powered-down state.

The block drives three active-high control bits: `pwrdn_o` (core power down), `clamp_early_o` (early isolation clamp) and `clamp_o` (isolation clamp). Power-up releases them in the order clamp, early clamp, power-down. Power-down asserts them in the exact reverse order. A programmable wait separates each step. The wait is counted in pulses of `tick_i`, so a 1 MHz tick with `WAIT_TICKS=100` gives a 100 µs wait between steps.

While a sequence runs, `busy_o` is high and every request is dropped. A held `drain_i` input releases the clients one at a time until the count reaches zero.

Top module: `pad_clamp_seq`

## Requirements
- R1: After reset, `pwrdn_o`, `clamp_early_o` and `clamp_o` are all 1, `count_o` is 0, and `busy_o` and `unbal_err_o` are 0.
- R2: An enable request accepted at count 0 sets the count to 1 and starts the release sequence. `clamp_o` falls on the clock edge that accepts the request. `clamp_early_o` falls after `WAIT_TICKS` further tick pulses. `pwrdn_o` falls after `WAIT_TICKS` more tick pulses. `busy_o` is high from acceptance until the edge on which `pwrdn_o` falls.
- R3: An enable request accepted at a nonzero count only adds one to the count, and the control bits do not change. At the maximum count (2^CNT_W−1) an enable request is ignored.
- R4: A disable request accepted at a count above 1 only subtracts one from the count, and the control bits do not change.
- R5: A disable request accepted at count 1 sets the count to 0 and starts the power-down sequence. `pwrdn_o` rises on the accepting edge. `clamp_early_o` rises after `WAIT_TICKS` tick pulses. `clamp_o` rises after `WAIT_TICKS` more tick pulses, and `busy_o` falls on that same edge.
- R6: A disable request at count 0 changes neither the count nor the control bits. Instead, `unbal_err_o` goes high for exactly one cycle, on the cycle after the request.
- R7: Enable and disable requests that arrive while `busy_o` is high are discarded. They are not queued.
- R8: An enable request and a disable request in the same cycle cancel each other, and neither has any effect.
- R9: While `drain_i` is high and the block is idle, the count drops by one on every cycle. When the count goes from 1 to 0, the power-down sequence of R5 runs. Enable and disable requests are ignored while `drain_i` is high, and draining at count 0 raises no error.
- R10: A sequence advances only on cycles where `tick_i` is high. With no tick, the sequence holds its current step indefinitely.
- R11: Whenever `clamp_early_o` is 0, `clamp_o` is also 0. Whenever `pwrdn_o` is 0, `clamp_early_o` is also 0. At most one control bit changes per clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timing tick; each high cycle counts one wait unit |
| en_req_i | input | 1 | Client enable request, one-cycle pulse |
| dis_req_i | input | 1 | Client disable request, one-cycle pulse |
| drain_i | input | 1 | Forced full release; level |
| pwrdn_o | output | 1 | Core power-down control, 1 = powered down |
| clamp_early_o | output | 1 | Early isolation clamp, 1 = clamped |
| clamp_o | output | 1 | Isolation clamp, 1 = clamped |
| busy_o | output | 1 | A sequence is in progress |
| count_o | output | CNT_W | Current reference count |
| unbal_err_o | output | 1 | One-cycle pulse for a disable request at count 0 |

## Verification
The bench walks the count through every value from 0 to the maximum and back. At each value it checks that only the 0↔1 transitions move the control bits. It also checks that an enable at the maximum count is dropped rather than wrapping the count to 0, which would otherwise power the domain down behind the clients' backs.

The bench measures the cycle on which each step of both sequences lands, with the tick held high and with hand-fed single ticks. A design that counts cycles instead of ticks, or that is off by one in its wait, lands a step on the wrong cycle. The bench sends requests while a sequence runs, sends simultaneous enable and disable requests, and sends a disable at count 0. A design that queued a request, let one request win, or decremented the count below zero would show a wrong count or a missing error pulse. The bench drains from each count with an enable held high, which catches a drain that skips the final power-down or lets the enable leak through.

// File: rtl/pad_clamp_pkg.sv
package pad_clamp_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_UP_A = 3'd1,
    SQ_UP_B = 3'd2,
    SQ_DN_A = 3'd3,
    SQ_DN_B = 3'd4
  } seq_state_t;

endpackage

// File: rtl/pad_clamp_wait.sv
module pad_clamp_wait #(
  parameter int WAIT_TICKS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int TW = (WAIT_TICKS < 2) ? 1 : $clog2(WAIT_TICKS);
  localparam logic [TW-1:0] LAST = TW'(WAIT_TICKS - 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign done_o = run_i && tick_i && (cnt_q == LAST);
  assign cnt_en = run_i && tick_i;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = done_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pad_clamp_refcnt.sv
module pad_clamp_refcnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = inc_i ^ dec_i;

  always_comb begin
    cnt_d = cnt_q;
    if (inc_i)      cnt_d = cnt_q + 1'b1;
    else if (dec_i) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/pad_clamp_fsm.sv
module pad_clamp_fsm
  import pad_clamp_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_req_i,
  input  logic             dis_req_i,
  input  logic             drain_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             wait_done_i,
  output logic             inc_o,
  output logic             dec_o,
  output logic             wait_run_o,
  output logic             busy_o,
  output logic             pwrdn_o,
  output logic             clamp_early_o,
  output logic             clamp_o,
  output logic             err_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  seq_state_t st_q, st_d;
  logic pd_q, pd_d, ec_q, ec_d, cl_q, cl_d, err_q, err_d;
  logic idle, cnt_zero, drain_op, en_op, dis_op, start_up, start_dn;

  assign idle     = (st_q == SQ_IDLE);
  assign cnt_zero = (count_i == '0);
  assign drain_op = idle && drain_i && !cnt_zero;
  assign en_op    = idle && !drain_i && en_req_i && !dis_req_i;
  assign dis_op   = idle && !drain_i && dis_req_i && !en_req_i;

  assign inc_o    = en_op && (count_i != CNT_MAX);
  assign dec_o    = drain_op || (dis_op && !cnt_zero);
  assign start_up = en_op && cnt_zero;
  assign start_dn = dec_o && (count_i == CNT_ONE);
  assign err_d    = dis_op && cnt_zero;

  always_comb begin
    st_d = st_q;
    pd_d = pd_q;
    ec_d = ec_q;
    cl_d = cl_q;
    unique case (st_q)
      SQ_IDLE: begin
        if (start_up) begin
          cl_d = 1'b0;
          st_d = SQ_UP_A;
        end else if (start_dn) begin
          pd_d = 1'b1;
          st_d = SQ_DN_A;
        end
      end
      SQ_UP_A: if (wait_done_i) begin ec_d = 1'b0; st_d = SQ_UP_B; end
      SQ_UP_B: if (wait_done_i) begin pd_d = 1'b0; st_d = SQ_IDLE; end
      SQ_DN_A: if (wait_done_i) begin ec_d = 1'b1; st_d = SQ_DN_B; end
      SQ_DN_B: if (wait_done_i) begin cl_d = 1'b1; st_d = SQ_IDLE; end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      pd_q  <= 1'b1;
      ec_q  <= 1'b1;
      cl_q  <= 1'b1;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      pd_q  <= pd_d;
      ec_q  <= ec_d;
      cl_q  <= cl_d;
      err_q <= err_d;
    end
  end

  assign wait_run_o    = !idle;
  assign busy_o        = !idle;
  assign pwrdn_o       = pd_q;
  assign clamp_early_o = ec_q;
  assign clamp_o       = cl_q;
  assign err_o         = err_q;
endmodule

// File: rtl/pad_clamp_seq.sv
module pad_clamp_seq #(
  parameter int CNT_W      = 4,
  parameter int WAIT_TICKS = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             en_req_i,
  input  logic             dis_req_i,
  input  logic             drain_i,
  output logic             pwrdn_o,
  output logic             clamp_early_o,
  output logic             clamp_o,
  output logic             busy_o,
  output logic [CNT_W-1:0] count_o,
  output logic             unbal_err_o
);
  logic inc, dec, wait_run, wait_done;

  pad_clamp_refcnt #(.CNT_W(CNT_W)) u_refcnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc_i   (inc),
    .dec_i   (dec),
    .count_o (count_o)
  );

  pad_clamp_wait #(.WAIT_TICKS(WAIT_TICKS)) u_wait (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (wait_run),
    .tick_i (tick_i),
    .done_o (wait_done)
  );

  pad_clamp_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .en_req_i      (en_req_i),
    .dis_req_i     (dis_req_i),
    .drain_i       (drain_i),
    .count_i       (count_o),
    .wait_done_i   (wait_done),
    .inc_o         (inc),
    .dec_o         (dec),
    .wait_run_o    (wait_run),
    .busy_o        (busy_o),
    .pwrdn_o       (pwrdn_o),
    .clamp_early_o (clamp_early_o),
    .clamp_o       (clamp_o),
    .err_o         (unbal_err_o)
  );
endmodule

// File: rtl/pad_clamp_seq_chk.sv
module pad_clamp_seq_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwrdn_o,
  input logic             clamp_early_o,
  input logic             clamp_o,
  input logic             busy_o,
  input logic [CNT_W-1:0] count_o,
  input logic             unbal_err_o
);
  assert_order_early_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !clamp_early_o |-> !clamp_o);

  assert_order_pwrdn_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrdn_o |-> !clamp_early_o);

  assert_one_bit_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $countones({pwrdn_o, clamp_early_o, clamp_o} ^
                        $past({pwrdn_o, clamp_early_o, clamp_o})) <= 1);

  assert_busy_holds_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(count_o));

  assert_err_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    unbal_err_o |-> (count_o == '0) && pwrdn_o && clamp_early_o && clamp_o);

  assert_idle_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && count_o != '0) |-> (!pwrdn_o && !clamp_early_o && !clamp_o));

  assert_idle_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && count_o == '0) |-> (pwrdn_o && clamp_early_o && clamp_o));

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (count_o == $past(count_o)) || (count_o == $past(count_o) + 1'b1) ||
             (count_o == $past(count_o) - 1'b1));
endmodule

bind pad_clamp_seq pad_clamp_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pwrdn_o       (pwrdn_o),
  .clamp_early_o (clamp_early_o),
  .clamp_o       (clamp_o),
  .busy_o        (busy_o),
  .count_o       (count_o),
  .unbal_err_o   (unbal_err_o)
);

// File: tb/pad_clamp_seq_bench.sv
module pad_clamp_seq_bench;
  localparam int CW   = 3;
  localparam int WT   = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic clk, rst_n, tick, en_req, dis_req, drain;
  logic pwrdn, early, clamp, busy, err;
  logic [CW-1:0] count;

  int n_tests = 0;
  int n_fail  = 0;
  int exp_cnt = 0;
  bit finished = 0;

  pad_clamp_seq #(.CNT_W(CW), .WAIT_TICKS(WT)) u_pad_clamp_seq (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .en_req_i(en_req),
    .dis_req_i(dis_req), .drain_i(drain), .pwrdn_o(pwrdn),
    .clamp_early_o(early), .clamp_o(clamp), .busy_o(busy),
    .count_o(count), .unbal_err_o(err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_bits(input string req, input int p, input int e, input int c);
    chk(req, {31'd0, pwrdn}, p);
    chk(req, {31'd0, early}, e);
    chk(req, {31'd0, clamp}, c);
  endtask

  function automatic logic get_bit(input int which);
    case (which)
      0: return pwrdn;
      1: return early;
      2: return clamp;
      default: return busy;
    endcase
  endfunction

  task automatic wait_bit(input int which, input logic val, output int n);
    n = 0;
    while (get_bit(which) !== val && n < 100) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic pulse(input logic e, input logic d);
    en_req = e; dis_req = d;
    @(negedge clk);
    en_req = 0; dis_req = 0;
  endtask

  task automatic up_from_zero();
    int n;
    pulse(1, 0);
    exp_cnt = 1;
    chk("R2 clamp released at accept", {31'd0, clamp}, 0);
    chk("R2 early still held", {31'd0, early}, 1);
    chk("R2 busy", {31'd0, busy}, 1);
    wait_bit(1, 1'b0, n);
    chk("R2 early release delay", n, WT);
    chk("R2 pwrdn still held", {31'd0, pwrdn}, 1);
    wait_bit(0, 1'b0, n);
    chk("R2 pwrdn release delay", n, WT);
    chk("R2 busy cleared", {31'd0, busy}, 0);
    chk("R2 count", int'(count), 1);
  endtask

  task automatic down_check();
    int n;
    chk("R5 pwrdn asserted at accept", {31'd0, pwrdn}, 1);
    chk("R5 early still released", {31'd0, early}, 0);
    chk("R5 busy", {31'd0, busy}, 1);
    wait_bit(1, 1'b1, n);
    chk("R5 early assert delay", n, WT);
    chk("R5 clamp still released", {31'd0, clamp}, 0);
    wait_bit(2, 1'b1, n);
    chk("R5 clamp assert delay", n, WT);
    chk("R5 busy cleared", {31'd0, busy}, 0);
    chk("R5 count", int'(count), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 0; tick = 1; en_req = 0; dis_req = 0; drain = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk_bits("R1 reset bits", 1, 1, 1);
    chk("R1 reset count", int'(count), 0);
    chk("R1 reset busy", {31'd0, busy}, 0);
    chk("R1 reset err", {31'd0, err}, 0);

    // R6 disable at zero
    pulse(0, 1);
    chk("R6 err pulse", {31'd0, err}, 1);
    chk("R6 count", int'(count), 0);
    chk_bits("R6 bits unchanged", 1, 1, 1);
    @(negedge clk);
    chk("R6 err single cycle", {31'd0, err}, 0);

    // R8 both at zero count
    pulse(1, 1);
    chk("R8 count unchanged", int'(count), 0);
    chk("R8 no sequence", {31'd0, busy}, 0);
    chk("R8 no err", {31'd0, err}, 0);

    // R2 / R7: up sequence with requests during busy
    pulse(1, 0);
    exp_cnt = 1;
    chk("R2 clamp released", {31'd0, clamp}, 0);
    pulse(1, 0);
    pulse(0, 1);
    chk("R7 count held while busy", int'(count), 1);
    wait_bit(0, 1'b0, n);
    chk("R7 count after sequence", int'(count), 1);
    chk_bits("R7 released", 0, 0, 0);
    repeat (3) @(negedge clk);
    chk("R7 nothing queued", int'(count), 1);
    chk("R7 no late sequence", {31'd0, busy}, 0);

    // R3 sweep up to max and overflow
    for (int k = 2; k <= CMAX; k++) begin
      pulse(1, 0);
      exp_cnt = k;
      chk("R3 increment", int'(count), exp_cnt);
      chk_bits("R3 bits stay released", 0, 0, 0);
      chk("R3 not busy", {31'd0, busy}, 0);
    end
    pulse(1, 0);
    chk("R3 saturate at max", int'(count), CMAX);
    chk_bits("R3 bits at max", 0, 0, 0);

    // R8 both at nonzero count
    pulse(1, 1);
    chk("R8 count unchanged nonzero", int'(count), CMAX);

    // R4 sweep down to one
    for (int k = CMAX - 1; k >= 1; k--) begin
      pulse(0, 1);
      exp_cnt = k;
      chk("R4 decrement", int'(count), exp_cnt);
      chk_bits("R4 bits stay released", 0, 0, 0);
      chk("R4 no err", {31'd0, err}, 0);
    end

    // R5 last release
    pulse(0, 1);
    exp_cnt = 0;
    down_check();

    // R10 tick gating
    tick = 0;
    pulse(1, 0);
    chk("R10 clamp released without tick", {31'd0, clamp}, 0);
    repeat (10) @(negedge clk);
    chk("R10 held without tick", {31'd0, early}, 1);
    for (int i = 0; i < WT; i++) begin
      chk("R10 early before last tick", {31'd0, early}, 1);
      tick = 1;
      @(negedge clk);
      tick = 0;
      @(negedge clk);
    end
    chk("R10 early after ticks", {31'd0, early}, 0);
    repeat (8) @(negedge clk);
    chk("R10 pwrdn held without tick", {31'd0, pwrdn}, 1);
    chk("R10 still busy", {31'd0, busy}, 1);
    tick = 1;
    wait_bit(0, 1'b0, n);
    chk("R10 pwrdn delay", n, WT);

    // return to zero
    pulse(0, 1);
    down_check();

    // R9 drain sweep from each count
    for (int k = 1; k <= CMAX; k++) begin
      up_from_zero();
      for (int j = 2; j <= k; j++) pulse(1, 0);
      chk("R9 prefill", int'(count), k);
      drain = 1; en_req = 1;
      for (int j = k - 1; j >= 1; j--) begin
        @(negedge clk);
        chk("R9 drain step", int'(count), j);
        chk_bits("R9 bits during drain", 0, 0, 0);
      end
      @(negedge clk);
      en_req = 0;
      down_check();
      repeat (3) @(negedge clk);
      chk("R9 zero stays", int'(count), 0);
      chk("R9 no err at zero", {31'd0, err}, 0);
      dis_req = 1;
      @(negedge clk);
      dis_req = 0;
      chk("R9 disable ignored while draining", {31'd0, err}, 0);
      drain = 0;
      @(negedge clk);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule